// File: doc/BRIEF.md
# Serial Flash Discovery Probe

This block runs once after power-up, before any other logic touches an attached SPI NOR flash. A single `start` pulse makes it walk the device through a fixed bring-up sequence. It reads the identification bytes and removes the factory block protection that one family of devices ships with. It then waits until the device reports that no internal write is in progress. Last, it reads the device's serial-flash discoverable-parameter header and its basic parameter table. From these it decides whether the device can be driven with 3-byte addresses and 4 KiB sector erase, and it works out the capacity.

The probe does not shift bits on the wire. It hands one command at a time to a byte-level SPI transaction engine through a request/acknowledge port. Each request carries an opcode, a flag for three address bytes, a flag for one dummy byte, and a count of bytes to read back. The engine returns the read bytes one per `rx_valid` strobe and pulses `txn_end` only after the last byte. The probe finishes with a one-cycle `done`. On success, `size_bytes` holds the capacity. On any failure, `error` is raised with `done` and `size_bytes` reads zero.

Top module: `flash_probe`

## Requirements
- R1: After reset `busy`, `done`, `error` and `txn_req` are low, `cs_n` is high and `size_bytes` is zero.
- R2: The first command after `start` is opcode 0x9F with no address and no dummy byte, reading 3 bytes.
- R3: If the first identify byte is 0xBF, the probe sends 0x06 and then polls 0x05 until status bit 1 is set. It then sends 0x98 with no address and nothing read. For any other first byte, neither 0x06 nor 0x98 is sent.
- R4: Status polls use opcode 0x05 with no address, reading 1 byte. If `POLL_LIMIT` consecutive polls all report busy, the probe fails. Busy means bit 0 set while waiting for idle, or bit 1 clear while waiting for write enable. Polls are separated by `GAP_CYCLES` idle cycles.
- R5: The header is read with opcode 0x5A, address 0, one dummy byte and 16 bytes read. The probe fails unless all of these hold: bytes 0..3 are 0x53 0x46 0x44 0x50, byte 5 is 1, byte 8 is 0 and byte 10 is 1.
- R6: The table is read with opcode 0x5A and one dummy byte, reading 8 bytes. Its address is {byte14, byte13, byte12} of the header, with byte14 as the most significant.
- R7: The probe fails if any of the following is true: table byte 0 bits [1:0] are not 01, table byte 1 is not 0x20, table byte 2 bit 2 is set, or table byte 7 bit 7 is set.
- R8: On success, `done` pulses for one cycle with `error` low. `size_bytes` then equals D/8 + 1, where D = {t7,t6,t5,t4} (t7 most significant). It holds that value until the next accepted start.
- R9: On failure, `done` and `error` pulse together for one cycle and `size_bytes` is zero.
- R10: `cs_n` is low while a command is requested and until its `txn_end`. It goes high on the cycle after `txn_end`, so it is high for at least one cycle between commands.
- R11: A `start` pulse while `busy` is high is ignored: the running probe finishes with exactly one `done` and the identify command is not reissued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a probe (ignored while busy) |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure flag, valid with `done` |
| size_bytes | output | 32 | Device capacity in bytes, zero on failure |
| cs_n | output | 1 | Chip select, low across a command |
| txn_req | output | 1 | Command request, held until `txn_ack` |
| txn_opcode | output | 8 | Command opcode |
| txn_addr | output | 24 | Address, sent most significant byte first |
| txn_addr_en | output | 1 | Send three address bytes |
| txn_dummy | output | 1 | Send one dummy byte after the address |
| txn_rd_len | output | 5 | Number of bytes to read back |
| txn_ack | input | 1 | Engine accepted the command |
| rx_valid | input | 1 | Read byte strobe |
| rx_byte | input | 8 | Read byte |
| txn_end | input | 1 | Command complete, after the last read byte |

## Verification
The assertions rely on the engine behaving as a well-formed peer. It raises `txn_ack` only while `txn_req` is high. It sends at most `txn_rd_len` bytes. It pulses `txn_end` once per command, only after acknowledging it and after the final byte. The bench's engine model reacts to requests on the falling clock edge and replays bytes from a per-case device image, so it never produces an unsolicited acknowledge or end pulse. Start pulses are also driven on the falling edge, including one deliberately placed in the middle of a probe.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

  localparam logic [7:0] OP_IDENT  = 8'h9F;
  localparam logic [7:0] OP_WR_EN  = 8'h06;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_UNLOCK = 8'h98;
  localparam logic [7:0] OP_DISCOV = 8'h5A;
  localparam logic [7:0] LOCKED_VENDOR = 8'hBF;
  localparam logic [7:0] SECTOR_ERASE_OP = 8'h20;

  typedef enum logic [3:0] {
    ST_IDLE, ST_IDENT, ST_WREN, ST_WEL_POLL, ST_WEL_GAP, ST_UNLOCK,
    ST_WIP_POLL, ST_WIP_GAP, ST_HDR, ST_TBL
  } probe_state_t;

  typedef enum logic [1:0] { PH_IDLE, PH_REQ, PH_WAIT } txn_phase_t;

  function automatic logic [7:0] byte_at(input logic [127:0] v, input int idx);
    return v[8*idx +: 8];
  endfunction

  // Header signature, revision and first-table checks.
  function automatic logic header_ok(input logic [127:0] h);
    logic sig;
    sig = byte_at(h, 0) == 8'h53 && byte_at(h, 1) == 8'h46 &&
          byte_at(h, 2) == 8'h44 && byte_at(h, 3) == 8'h50;
    return sig && byte_at(h, 5) == 8'd1 && byte_at(h, 8) == 8'd0 &&
           byte_at(h, 10) == 8'd1;
  endfunction

  // Pointer fields are little-endian; command address is big-endian.
  function automatic logic [23:0] table_pointer(input logic [127:0] h);
    return {byte_at(h, 14), byte_at(h, 13), byte_at(h, 12)};
  endfunction

  function automatic logic table_ok(input logic [127:0] t);
    logic [7:0] t0, t1, t2, t7;
    t0 = byte_at(t, 0);
    t1 = byte_at(t, 1);
    t2 = byte_at(t, 2);
    t7 = byte_at(t, 7);
    return t0[1:0] == 2'b01 && t1 == SECTOR_ERASE_OP && !t2[2] && !t7[7];
  endfunction

  function automatic logic [31:0] capacity_bytes(input logic [127:0] t);
    logic [31:0] density_bits_m1;
    density_bits_m1 = {byte_at(t, 7), byte_at(t, 6), byte_at(t, 5), byte_at(t, 4)};
    return (density_bits_m1 >> 3) + 32'd1;
  endfunction

endpackage

// File: rtl/probe_rx_capture.sv
module probe_rx_capture #(
  parameter int MAX_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_byte,
  output logic [MAX_BYTES*8-1:0] bytes_o
);
  localparam int IW = $clog2(MAX_BYTES) + 1;

  logic [IW-1:0] wr_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   wr_idx <= '0;
    else if (clear)                               wr_idx <= '0;
    else if (rx_valid && wr_idx < IW'(MAX_BYTES)) wr_idx <= wr_idx + 1'b1;
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                bytes_o[8*g +: 8] <= 8'h00;
      else if (rx_valid && wr_idx == IW'(g))     bytes_o[8*g +: 8] <= rx_byte;
    end
  end
endmodule

// File: rtl/probe_poll_timer.sv
module probe_poll_timer #(
  parameter int POLL_LIMIT = 10000,
  parameter int GAP_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic count_busy,
  input  logic gap_load,
  output logic last_poll,
  output logic gap_over
);
  localparam int CW = $clog2(POLL_LIMIT + 1);
  localparam int GW = $clog2(GAP_CYCLES + 1);

  logic [CW-1:0] polls;
  logic [GW-1:0] gap_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          polls <= '0;
    else if (clear)      polls <= '0;
    else if (count_busy) polls <= polls + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              gap_left <= '0;
    else if (gap_load)       gap_left <= GW'(GAP_CYCLES);
    else if (gap_left != '0) gap_left <= gap_left - 1'b1;
  end

  // The current busy answer is the last one allowed.
  assign last_poll = (polls == CW'(POLL_LIMIT - 1));
  assign gap_over  = (gap_left == '0);
endmodule

// File: rtl/flash_probe.sv
module flash_probe
  import flash_probe_pkg::*;
#(
  parameter int POLL_LIMIT = 10000,
  parameter int GAP_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic [31:0] size_bytes,
  output logic        cs_n,
  output logic        txn_req,
  output logic [7:0]  txn_opcode,
  output logic [23:0] txn_addr,
  output logic        txn_addr_en,
  output logic        txn_dummy,
  output logic [4:0]  txn_rd_len,
  input  logic        txn_ack,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        txn_end
);
  localparam int BUF_BYTES = 16;

  probe_state_t state, nxt_state;
  txn_phase_t   phase;
  logic [23:0]  tbl_addr;
  logic [BUF_BYTES*8-1:0] rx_buf;
  logic [7:0]   first_byte;

  // Named events
  logic cmd_finished, finish_ok, finish_bad;
  logic timer_clear, poll_busy_note, gap_load, last_poll, gap_over;
  logic accept_start;

  assign accept_start = (state == ST_IDLE) && start;
  assign cmd_finished = (phase == PH_WAIT) && txn_end;
  assign first_byte   = byte_at(rx_buf, 0);

  probe_rx_capture #(.MAX_BYTES(BUF_BYTES)) rx_cap_i (
    .clk(clk), .rst_n(rst_n), .clear(txn_ack),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .bytes_o(rx_buf)
  );

  probe_poll_timer #(.POLL_LIMIT(POLL_LIMIT), .GAP_CYCLES(GAP_CYCLES)) timer_i (
    .clk(clk), .rst_n(rst_n), .clear(timer_clear),
    .count_busy(poll_busy_note), .gap_load(gap_load),
    .last_poll(last_poll), .gap_over(gap_over)
  );

  // Decide what follows a finished command.
  always_comb begin
    nxt_state      = state;
    finish_ok      = 1'b0;
    finish_bad     = 1'b0;
    timer_clear    = accept_start;
    poll_busy_note = 1'b0;
    gap_load       = 1'b0;
    if (cmd_finished) begin
      unique case (state)
        ST_IDENT: begin
          timer_clear = 1'b1;
          nxt_state   = (first_byte == LOCKED_VENDOR) ? ST_WREN : ST_WIP_POLL;
        end
        ST_WREN: begin
          timer_clear = 1'b1;
          nxt_state   = ST_WEL_POLL;
        end
        ST_WEL_POLL: begin
          if (first_byte[1])  nxt_state = ST_UNLOCK;
          else if (last_poll) finish_bad = 1'b1;
          else begin
            nxt_state = ST_WEL_GAP; poll_busy_note = 1'b1; gap_load = 1'b1;
          end
        end
        ST_UNLOCK: begin
          timer_clear = 1'b1;
          nxt_state   = ST_WIP_POLL;
        end
        ST_WIP_POLL: begin
          if (!first_byte[0]) nxt_state = ST_HDR;
          else if (last_poll) finish_bad = 1'b1;
          else begin
            nxt_state = ST_WIP_GAP; poll_busy_note = 1'b1; gap_load = 1'b1;
          end
        end
        ST_HDR: begin
          if (header_ok(rx_buf)) nxt_state = ST_TBL;
          else                   finish_bad = 1'b1;
        end
        ST_TBL: begin
          if (table_ok(rx_buf)) finish_ok  = 1'b1;
          else                  finish_bad = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      phase      <= PH_IDLE;
      done       <= 1'b0;
      error      <= 1'b0;
      size_bytes <= '0;
      tbl_addr   <= '0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          size_bytes <= '0;
          state      <= ST_IDENT;
        end
        ST_WEL_GAP: if (gap_over) state <= ST_WEL_POLL;
        ST_WIP_GAP: if (gap_over) state <= ST_WIP_POLL;
        default: begin
          unique case (phase)
            PH_IDLE: phase <= PH_REQ;
            PH_REQ:  if (txn_ack) phase <= PH_WAIT;
            default: if (txn_end) phase <= PH_IDLE;
          endcase
          if (cmd_finished) begin
            if (state == ST_HDR) tbl_addr <= table_pointer(rx_buf);
            if (finish_ok) begin
              state      <= ST_IDLE;
              done       <= 1'b1;
              size_bytes <= capacity_bytes(rx_buf);
            end else if (finish_bad) begin
              state      <= ST_IDLE;
              done       <= 1'b1;
              error      <= 1'b1;
              size_bytes <= '0;
            end else begin
              state <= nxt_state;
            end
          end
        end
      endcase
    end
  end

  // Command fields follow the state.
  always_comb begin
    txn_opcode  = OP_STATUS;
    txn_addr    = '0;
    txn_addr_en = 1'b0;
    txn_dummy   = 1'b0;
    txn_rd_len  = 5'd1;
    unique case (state)
      ST_IDENT:  begin txn_opcode = OP_IDENT;  txn_rd_len = 5'd3; end
      ST_WREN:   begin txn_opcode = OP_WR_EN;  txn_rd_len = 5'd0; end
      ST_UNLOCK: begin txn_opcode = OP_UNLOCK; txn_rd_len = 5'd0; end
      ST_HDR: begin
        txn_opcode = OP_DISCOV; txn_addr_en = 1'b1; txn_dummy = 1'b1;
        txn_rd_len = 5'd16;
      end
      ST_TBL: begin
        txn_opcode = OP_DISCOV; txn_addr_en = 1'b1; txn_dummy = 1'b1;
        txn_addr = tbl_addr; txn_rd_len = 5'd8;
      end
      default: ;
    endcase
  end

  assign busy    = (state != ST_IDLE);
  assign txn_req = (phase == PH_REQ);
  assign cs_n    = (phase == PH_IDLE);
endmodule

// File: rtl/flash_probe_chk.sv
module flash_probe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        error,
  input logic [31:0] size_bytes,
  input logic        cs_n,
  input logic        txn_req,
  input logic [7:0]  txn_opcode,
  input logic        txn_addr_en,
  input logic        txn_dummy,
  input logic [4:0]  txn_rd_len,
  input logic        txn_ack,
  input logic        txn_end
);
  // R10
  req_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_req |-> !cs_n);
  // R10
  end_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end && !cs_n && !txn_req) |=> cs_n);
  // R9
  fail_zero_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (done && size_bytes == 32'd0));
  // R8
  ok_size_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> size_bytes != 32'd0);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R4
  status_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && txn_opcode == 8'h05) |-> (!txn_addr_en && txn_rd_len == 5'd1));
  // R5
  discov_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && txn_opcode == 8'h5A) |-> (txn_addr_en && txn_dummy));
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && !txn_ack) |=> (txn_req && $stable(txn_opcode)));
endmodule

bind flash_probe flash_probe_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
  .size_bytes(size_bytes), .cs_n(cs_n), .txn_req(txn_req),
  .txn_opcode(txn_opcode), .txn_addr_en(txn_addr_en), .txn_dummy(txn_dummy),
  .txn_rd_len(txn_rd_len), .txn_ack(txn_ack), .txn_end(txn_end)
);

// File: tb/flash_probe_tb_top.sv
module flash_probe_tb_top;
  localparam int LIM = 6;
  localparam int GAP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, error, cs_n, txn_req, txn_addr_en, txn_dummy;
  logic [31:0] size_bytes;
  logic [7:0]  txn_opcode;
  logic [23:0] txn_addr;
  logic [4:0]  txn_rd_len;
  logic txn_ack = 1'b0, rx_valid = 1'b0, txn_end = 1'b0;
  logic [7:0] rx_byte = 8'h00;

  always #4 clk = ~clk;

  flash_probe #(.POLL_LIMIT(LIM), .GAP_CYCLES(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .error(error), .size_bytes(size_bytes), .cs_n(cs_n), .txn_req(txn_req),
    .txn_opcode(txn_opcode), .txn_addr(txn_addr), .txn_addr_en(txn_addr_en),
    .txn_dummy(txn_dummy), .txn_rd_len(txn_rd_len), .txn_ack(txn_ack),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .txn_end(txn_end)
  );

  int n_cmp = 0, n_bad = 0;
  bit summary_done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Device image and observations
  logic [7:0] m_id0;
  int         m_wel_wait, m_wip;
  logic [7:0] m_hdr [16];
  logic [7:0] m_tbl [8];
  bit   m_wel_phase, m_saw_wren, m_saw_unlock;
  int   m_ident_cnt, m_cs_bad, m_shape_bad, m_done_cnt;
  logic [23:0] m_tbl_addr_seen;

  task automatic image_default();
    m_id0 = 8'hC2; m_wel_wait = 0; m_wip = 0;
    m_hdr[0] = 8'h53; m_hdr[1] = 8'h46; m_hdr[2] = 8'h44; m_hdr[3] = 8'h50;
    m_hdr[4] = 8'h06; m_hdr[5] = 8'h01; m_hdr[6] = 8'h01; m_hdr[7] = 8'hFF;
    m_hdr[8] = 8'h00; m_hdr[9] = 8'h06; m_hdr[10] = 8'h01; m_hdr[11] = 8'h10;
    m_hdr[12] = 8'h30; m_hdr[13] = 8'h00; m_hdr[14] = 8'h00; m_hdr[15] = 8'hFF;
    m_tbl[0] = 8'hE5; m_tbl[1] = 8'h20; m_tbl[2] = 8'hF1; m_tbl[3] = 8'hFF;
    m_tbl[4] = 8'hFF; m_tbl[5] = 8'hFF; m_tbl[6] = 8'hFF; m_tbl[7] = 8'h00;
    m_wel_phase = 0; m_saw_wren = 0; m_saw_unlock = 0;
    m_ident_cnt = 0; m_cs_bad = 0; m_shape_bad = 0;
    m_tbl_addr_seen = 24'hFFFFFF;
  endtask

  // Engine model: answers on falling edges.
  initial begin
    logic [7:0] resp [16];
    int n;
    forever begin
      @(negedge clk);
      if (txn_req) begin
        n = int'(txn_rd_len);
        for (int i = 0; i < 16; i++) resp[i] = 8'h00;
        case (txn_opcode)
          8'h9F: begin
            m_ident_cnt++;
            resp[0] = m_id0; resp[1] = 8'h25; resp[2] = 8'h8E;
            if (n != 3 || txn_addr_en || txn_dummy) m_shape_bad++;
          end
          8'h06: begin m_saw_wren = 1; m_wel_phase = 1; end
          8'h98: begin
            m_saw_unlock = 1; m_wel_phase = 0;
            if (n != 0 || txn_addr_en) m_shape_bad++;
          end
          8'h05: begin
            if (m_wel_phase) begin
              if (m_wel_wait > 0) m_wel_wait--; else resp[0] = 8'h02;
            end else begin
              if (m_wip > 0) begin m_wip--; resp[0] = 8'h01; end
            end
          end
          8'h5A: begin
            if (txn_addr == 24'h0) begin
              for (int i = 0; i < 16; i++) resp[i] = m_hdr[i];
              if (n != 16) m_shape_bad++;
            end else begin
              m_tbl_addr_seen = txn_addr;
              for (int i = 0; i < 8; i++) resp[i] = m_tbl[i];
              if (n != 8) m_shape_bad++;
            end
          end
          default: m_shape_bad++;
        endcase
        txn_ack = 1'b1;
        @(negedge clk);
        txn_ack = 1'b0;
        for (int i = 0; i < n; i++) begin
          if (cs_n) m_cs_bad++;
          rx_valid = 1'b1; rx_byte = resp[i];
          @(negedge clk);
        end
        rx_valid = 1'b0;
        if (cs_n) m_cs_bad++;
        txn_end = 1'b1;
        @(negedge clk);
        txn_end = 1'b0;
        if (!cs_n) m_cs_bad++;
      end
    end
  end

  typedef struct { bit err; logic [31:0] sz; string tag; } exp_t;
  exp_t sb_q[$];

  function automatic exp_t predict(input string tag);
    exp_t e;
    logic [31:0] dens;
    e.err = 1; e.sz = 0; e.tag = tag;
    if (m_id0 == 8'hBF && m_wel_wait >= LIM) return e;
    if (m_wip >= LIM) return e;
    if (m_hdr[0] != "S" || m_hdr[1] != "F" || m_hdr[2] != "D" || m_hdr[3] != "P") return e;
    if (m_hdr[5] != 8'd1 || m_hdr[8] != 8'd0 || m_hdr[10] != 8'd1) return e;
    if ((m_tbl[0] % 4) != 1 || m_tbl[1] != 8'h20) return e;
    if ((m_tbl[2] & 8'h04) != 0 || m_tbl[7] >= 8'h80) return e;
    dens = m_tbl[7] * 32'h1000000 + m_tbl[6] * 32'h10000 + m_tbl[5] * 32'h100 + m_tbl[4];
    e.err = 0; e.sz = dens / 8 + 1;
    return e;
  endfunction

  // Monitor: pops expectations when the design completes.
  initial begin
    exp_t e;
    m_done_cnt = 0;
    forever begin
      @(negedge clk);
      if (done) begin
        m_done_cnt++;
        if (sb_q.size() == 0) chk(0, "R11 unexpected done", 32'd1, 32'd0);
        else begin
          e = sb_q.pop_front();
          chk(error == e.err, {e.tag, " error"}, 32'(error), 32'(e.err));
          chk(size_bytes == e.sz, {e.tag, " size"}, size_bytes, e.sz);
        end
      end
    end
  end

  // Driver: push expectation, start, wait for completion.
  task automatic run_case(input string tag, input bit poke_midway);
    exp_t e;
    int d0, cyc;
    bit bf, lock_expected;
    logic [23:0] taddr;
    e = predict(tag);
    bf = (m_id0 == 8'hBF);
    lock_expected = bf && m_wel_wait < LIM;
    taddr = {m_hdr[14], m_hdr[13], m_hdr[12]};
    sb_q.push_back(e);
    d0 = m_done_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (m_done_cnt == d0 && cyc < 5000) begin
      if (poke_midway && cyc == 20) start = 1'b1;
      else start = 1'b0;
      @(negedge clk); cyc++;
    end
    start = 1'b0;
    if (cyc >= 5000) chk(0, {tag, " completion timeout"}, 32'(cyc), 32'd5000);
    repeat (40) @(negedge clk);
    // R2 one identify per probe, with the right shape
    chk(m_ident_cnt == 1, {tag, " R2 identify count"}, 32'(m_ident_cnt), 32'd1);
    chk(m_shape_bad == 0, {tag, " R2/R5/R6 command shape"}, 32'(m_shape_bad), 32'd0);
    // R3 unlock only for the locked vendor
    chk(m_saw_wren == bf, {tag, " R3 write-enable sent"}, 32'(m_saw_wren), 32'(bf));
    chk(m_saw_unlock == lock_expected, {tag, " R3 unlock sent"},
        32'(m_saw_unlock), 32'(lock_expected));
    // R10 chip select framing
    chk(m_cs_bad == 0, {tag, " R10 cs framing"}, 32'(m_cs_bad), 32'd0);
    // R6 table address
    if (!e.err)
      chk(m_tbl_addr_seen == taddr, {tag, " R6 table address"},
          32'(m_tbl_addr_seen), 32'(taddr));
    // R11 exactly one completion
    chk(m_done_cnt == d0 + 1, {tag, " R11 done count"}, 32'(m_done_cnt), 32'(d0 + 1));
    // R8 size held after done
    chk(size_bytes == e.sz, {tag, " R8 size held"}, size_bytes, e.sz);
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog expired", 32'd0, 32'd1);
    summary();
  end

  initial begin
    image_default();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !error && !txn_req, "R1 control outputs idle",
        {28'd0, busy, done, error, txn_req}, 32'd0);
    chk(cs_n == 1'b1, "R1 cs_n high", 32'(cs_n), 32'd1);
    chk(size_bytes == 32'd0, "R1 size zero", size_bytes, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    image_default();                                  run_case("R8 plain device", 0);
    image_default(); m_id0 = 8'hBF; m_wel_wait = 2; m_wip = 3;
                                                      run_case("R3 locked vendor", 0);
    image_default(); m_wip = LIM - 1;                 run_case("R4 last poll idle", 0);
    image_default(); m_wip = LIM;                     run_case("R4 poll timeout", 0);
    image_default(); m_id0 = 8'hBF; m_wel_wait = LIM; run_case("R4 enable timeout", 0);
    image_default(); m_hdr[2] = 8'h45;                run_case("R5 bad signature", 0);
    image_default(); m_hdr[5] = 8'h02;                run_case("R5 bad revision", 0);
    image_default(); m_hdr[8] = 8'h01;                run_case("R5 byte8 nonzero", 0);
    image_default(); m_hdr[10] = 8'h00;               run_case("R5 byte10 wrong", 0);
    image_default(); m_tbl[0] = 8'hE6;                run_case("R7 erase size field", 0);
    image_default(); m_tbl[1] = 8'hD8;                run_case("R7 erase opcode", 0);
    image_default(); m_tbl[2] = 8'hF5;                run_case("R7 four-byte addressing", 0);
    image_default(); m_tbl[7] = 8'h80;                run_case("R7 huge density", 0);
    image_default(); m_hdr[12] = 8'h30; m_hdr[13] = 8'h01; m_hdr[14] = 8'h02;
    m_tbl[4] = 8'hFF; m_tbl[5] = 8'hFF; m_tbl[6] = 8'hFF; m_tbl[7] = 8'h07;
                                                      run_case("R6 R8 remote table", 0);
    image_default(); m_wip = 2;                       run_case("R11 start while busy", 1);
    image_default(); m_hdr[0] = 8'h00;                run_case("R9 fail clears size", 0);

    chk(sb_q.size() == 0, "R11 scoreboard drained", 32'(sb_q.size()), 32'd0);
    summary();
  end
endmodule